// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects up to 32 interrupt inputs and presents them to a processor as one active-low normal request line, `irq_n`. Each input has its own configuration word. The word sets a 3-bit priority (7 is the most urgent), chooses edge or level triggering, enables or disables the input, and holds a vector value that software reads back when the input is acknowledged. A separate fast input has its own enable and trigger mode and drives a second active-low line, `fiq_n`. The fast input never touches the normal path.

While an interrupt is in service, the controller remembers its priority in a hardware stack of up to eight levels. The top entry is the current level. The normal request is raised only for a pending, enabled source whose priority is strictly above the current level. This is what lets a more urgent source preempt the handler that is running. Reading the vector register acknowledges the winning source and pushes its priority. Writing the end-of-interrupt register pops one level and decides the request line again against the level that was restored.

The register port is a plain single-cycle strobe interface. A read returns its data in the same cycle as the strobe. Any side effects of a read or write take place at the clock edge that ends that cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset both `irq_n` and `fiq_n` are high, the priority stack is empty, and every source and the fast input are disabled.
- R2: A source whose enable bit is 0 neither sets its edge latch nor takes part in arbitration. An edge that arrives while the source is disabled does not cause a request once the source is enabled later.
- R3: Among pending enabled sources, the one with the highest priority wins. A read of address 0x00 while `irq_n` is low returns the winner's vector field in `bus_rdata[26:0]`, with the upper bits zero.
- R4: When pending sources share the highest priority, the lowest-numbered one wins.
- R5: A read of address 0x00 while `irq_n` is low acknowledges the winner. It pushes the winner's priority, which becomes the current level, and it clears the winner's edge latch. `irq_n` then rises unless another pending source is strictly above the new level.
- R6: While an interrupt is in service, `irq_n` goes low for a pending source whose priority is strictly higher than the current level. It stays high for a source at an equal or lower priority.
- R7: A write to address 0x02 pops the current level. `irq_n` is then low exactly when a pending source lies strictly above the restored level. This holds even when that source's priority is equal to or below the level that just ended. With the stack empty, any pending source counts as above.
- R8: A write to address 0x02 while the stack is empty changes nothing.
- R9: A level-triggered source stays pending for as long as its synchronized input is high, including after it has been acknowledged. It stops being pending once the input falls.
- R10: An edge-triggered source is pending only after a rising edge of its synchronized input. Holding the input high after an acknowledge does not raise a new request.
- R11: The fast path uses its own line, `fiq_n`, and leaves `irq_n` alone. The fast configuration word is written at address 0x03 (bit 0 enable, bit 1 edge mode). A read of address 0x01 returns zero and clears the fast edge latch, so in edge mode `fiq_n` is high in the following cycle.
- R12: Up to eight levels can be in service at once. Because every push is strictly above the level below it, eight nested acknowledges of priorities 0 to 7 fill the stack without losing any level.
- R13: Source i is configured by a write to address 0x40+i. The word carries bits [2:0] priority, bit 3 edge mode (1 = edge), bit 4 enable, and bits [31:5] the vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Asynchronous interrupt inputs, one per source |
| fast_in | input | 1 | Asynchronous fast interrupt input |
| bus_addr | input | 7 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_n | output | 1 | Active-low normal interrupt request |
| fiq_n | output | 1 | Active-low fast interrupt request |

## Verification
Any fault in the stack shows up on `irq_n` in the same cycle as the push or pop that caused it. A pointer off by one, or a wrong top entry, makes the line fall or stay high against the restored level right after an end-of-interrupt write, so the bench reads `irq_n` directly after each acknowledge and each pop. An edge latch that fails to clear shows as a renewed request as soon as the stack empties. Wrong arbitration shows as a wrong vector on the very next read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;
    localparam int PRIO_W = 3;
    localparam int VEC_W  = DATA_W - PRIO_W - 2;

    localparam logic [ADDR_W-1:0] A_VEC_RD   = 7'h00;
    localparam logic [ADDR_W-1:0] A_FVEC_RD  = 7'h01;
    localparam logic [ADDR_W-1:0] A_EOI_WR   = 7'h02;
    localparam logic [ADDR_W-1:0] A_FAST_CFG = 7'h03;

    typedef logic [PRIO_W-1:0] prio_t;

    // Per-source configuration word, laid out exactly as written on the bus.
    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             en;
        logic             edge_mode;
        prio_t            prio;
    } src_cfg_t;

    typedef struct packed {
        logic en;
        logic edge_mode;
    } fast_cfg_t;

    // True when a valid candidate beats the current best by strict priority.
    function automatic logic outranks(input logic cand_ok, input prio_t cand,
                                      input logic best_ok, input prio_t best);
        return cand_ok && (!best_ok || (cand > best));
    endfunction

    // Upper half of the address space holds the per-source words.
    function automatic logic is_cfg_addr(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

endpackage

// File: rtl/irqc_src_front.sv
module irqc_src_front #(
    parameter int N    = 32,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] en,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    for (genvar g = 0; g < N; g++) begin : g_src
        logic [SYNC-1:0] sync_q;
        logic            prev_q;
        logic            latch_q;
        logic            lvl;
        logic            rise;

        assign lvl  = sync_q[SYNC-1];
        assign rise = lvl & ~prev_q & en[g] & edge_mode[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q  <= '0;
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                sync_q  <= {sync_q[SYNC-2:0], raw[g]};
                prev_q  <= lvl;
                // clear wins over a rise in the same cycle
                latch_q <= (latch_q | rise) & ~clr[g];
            end
        end

        assign pend[g] = en[g] & (edge_mode[g] ? latch_q : lvl);
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter  int N     = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             pend,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx,
    output prio_t                    win_prio
);

    // Ascending scan with strict compare: ties keep the lower index.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < N; i++) begin
            if (outranks(pend[i], prio[i], win_valid, win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/irqc_level_stack.sv
module irqc_level_stack
    import irqc_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  prio_t            push_prio,
    input  logic             pop,
    output logic [CNT_W-1:0] depth,
    output prio_t            top,
    output logic             empty
);

    prio_t            mem_q [DEPTH];
    logic [CNT_W-1:0] depth_q;
    logic             full;

    assign full  = (depth_q == CNT_W'(DEPTH));
    assign empty = (depth_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else if (push && !full) begin
            depth_q <= depth_q + 1'b1;
        end else if (pop && !empty) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push && !full) begin
            mem_q[PTR_W'(depth_q)] <= push_prio;
        end
    end

    assign top   = empty ? '0 : mem_q[PTR_W'(depth_q - 1'b1)];
    assign depth = depth_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int STACK_DEPTH = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               fast_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n,
    output logic               fiq_n
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int SEL_W = ADDR_W - 1;
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    // ---------------- configuration storage ----------------
    src_cfg_t           cfg_q [NUM_SRC];
    fast_cfg_t          fast_cfg_q;
    logic               cfg_wr;
    logic [SEL_W-1:0]   cfg_sel;

    assign cfg_wr  = bus_wr && is_cfg_addr(bus_addr);
    assign cfg_sel = bus_addr[SEL_W-1:0];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (cfg_wr && cfg_sel == SEL_W'(i)) begin
                cfg_q[i] <= src_cfg_t'(bus_wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_cfg_q <= '0;
        end else if (bus_wr && bus_addr == A_FAST_CFG) begin
            fast_cfg_q.en        <= bus_wdata[0];
            fast_cfg_q.edge_mode <= bus_wdata[1];
        end
    end

    logic [NUM_SRC-1:0]             en_v;
    logic [NUM_SRC-1:0]             edge_v;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            en_v[i]   = cfg_q[i].en;
            edge_v[i] = cfg_q[i].edge_mode;
            prio_v[i] = cfg_q[i].prio;
        end
    end

    // ---------------- bus decode ----------------
    logic vec_rd, vec_ack, fvec_rd, eoi_wr;
    logic req;

    assign vec_rd  = bus_rd && (bus_addr == A_VEC_RD);
    assign fvec_rd = bus_rd && (bus_addr == A_FVEC_RD);
    assign eoi_wr  = bus_wr && (bus_addr == A_EOI_WR);
    assign vec_ack = vec_rd && req;

    // ---------------- normal sources ----------------
    logic [NUM_SRC-1:0] pend_v;
    logic [NUM_SRC-1:0] clr_v;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    prio_t              win_prio;

    assign clr_v = vec_ack ? (NUM_SRC'(1) << win_idx) : '0;

    irqc_src_front #(
        .N    (NUM_SRC),
        .SYNC (SYNC_STAGES)
    ) u_front (
        .clk       (clk),
        .rst       (rst),
        .raw       (src_in),
        .en        (en_v),
        .edge_mode (edge_v),
        .clr       (clr_v),
        .pend      (pend_v)
    );

    irqc_arbiter #(
        .N (NUM_SRC)
    ) u_arb (
        .pend      (pend_v),
        .prio      (prio_v),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    // ---------------- in-service level stack ----------------
    logic [CNT_W-1:0] stk_depth;
    prio_t            stk_top;
    logic             stk_empty;

    irqc_level_stack #(
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (vec_ack),
        .push_prio (win_prio),
        .pop       (eoi_wr),
        .depth     (stk_depth),
        .top       (stk_top),
        .empty     (stk_empty)
    );

    // Request only when the winner is strictly above the current level.
    assign req   = outranks(win_valid, win_prio, !stk_empty, stk_top);
    assign irq_n = ~req;

    // ---------------- fast path ----------------
    logic fast_pend;

    irqc_src_front #(
        .N    (1),
        .SYNC (SYNC_STAGES)
    ) u_fast (
        .clk       (clk),
        .rst       (rst),
        .raw       (fast_in),
        .en        (fast_cfg_q.en),
        .edge_mode (fast_cfg_q.edge_mode),
        .clr       (fvec_rd),
        .pend      (fast_pend)
    );

    assign fiq_n = ~fast_pend;

    // ---------------- read data ----------------
    always_comb begin
        bus_rdata = '0;
        if (vec_ack) begin
            bus_rdata[VEC_W-1:0] = cfg_q[win_idx].vec;
        end
    end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_n,
    input logic             fiq_n,
    input logic             vec_ack,
    input logic             eoi_wr,
    input logic             fvec_rd,
    input logic             fast_edge,
    input logic [CNT_W-1:0] stk_depth
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (irq_n && fiq_n));

    // R5
    ack_push_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && stk_depth < CNT_W'(DEPTH)) |=> (stk_depth == $past(stk_depth) + 1'b1));

    // R7
    eoi_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && stk_depth != '0) |=> (stk_depth == $past(stk_depth) - 1'b1));

    // R8
    eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && stk_depth == '0) |=> (stk_depth == '0));

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        stk_depth <= CNT_W'(DEPTH));

    // R11
    fast_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (fvec_rd && fast_edge) |=> fiq_n);

endmodule

bind prio_irq_ctrl irqc_chk #(
    .DEPTH (STACK_DEPTH),
    .CNT_W (CNT_W)
) u_irqc_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_n     (irq_n),
    .fiq_n     (fiq_n),
    .vec_ack   (vec_ack),
    .eoi_wr    (eoi_wr),
    .fvec_rd   (fvec_rd),
    .fast_edge (fast_cfg_q.edge_mode),
    .stk_depth (stk_depth)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    import irqc_pkg::*;

    localparam int N = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic [N-1:0]      src_in;
    logic              fast_in;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_rd;
    logic              bus_wr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_n;
    logic              fiq_n;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src_in),
        .fast_in   (fast_in),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n),
        .fiq_n     (fiq_n)
    );

    // Level-mode arbitration vectors: source mask and expected winner (-1 = none).
    // Priority of source i in this table run is (i*5) mod 8.
    localparam logic [31:0] ROW_MASK [9] = '{
        32'h0000_0002, 32'h0000_0202, 32'h0000_0003, 32'h8000_0100, 32'h0000_0048,
        32'h0010_0001, 32'h0000_0101, 32'hFFFF_FFFF, 32'h0000_0000
    };
    localparam int ROW_WIN [9] = '{1, 1, 1, 31, 3, 20, 0, 3, -1};

    function automatic logic [31:0] vec_of(input int i);
        return 32'h1000 + 32'(i) * 32'd16;
    endfunction

    function automatic logic [31:0] cfg_word(input int prio, input bit edge_m,
                                             input bit en, input int i);
        logic [26:0] v;
        v = 27'(vec_of(i));
        return {v, en, edge_m, 3'(prio)};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        src_in    = '0;
        fast_in   = 1'b0;
        bus_addr  = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic pulse(input int i);
        src_in[i] = 1'b1;
        tick(3);
        src_in[i] = 1'b0;
        tick(3);
    endtask

    task automatic cfg_src(input int i, input int prio, input bit edge_m, input bit en);
        bus_write(7'h40 + 7'(i), cfg_word(prio, edge_m, en, i));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;

        // ---- R1 reset state ----
        do_reset();
        chk("R1 irq_n after reset", 32'(irq_n), 32'd1);
        chk("R1 fiq_n after reset", 32'(fiq_n), 32'd1);
        src_in = '1;
        fast_in = 1'b1;
        tick(5);
        chk("R1 sources disabled after reset", 32'(irq_n), 32'd1);
        chk("R1 fast disabled after reset", 32'(fiq_n), 32'd1);
        src_in = '0;
        fast_in = 1'b0;
        tick(4);

        // ---- table: level mode arbitration, R3 R4 R5 R9 R13 ----
        for (int i = 0; i < N; i++) cfg_src(i, (i * 5) % 8, 1'b0, 1'b1);
        for (int r = 0; r < 9; r++) begin
            src_in = ROW_MASK[r];
            tick(4);
            chk($sformatf("R3 row %0d request", r), 32'(irq_n), (ROW_WIN[r] < 0) ? 32'd1 : 32'd0);
            if (ROW_WIN[r] >= 0) begin
                bus_read(A_VEC_RD, rd);
                chk($sformatf("R3 R4 R13 row %0d vector", r), rd, vec_of(ROW_WIN[r]));
                chk($sformatf("R5 row %0d drop after ack", r), 32'(irq_n), 32'd1);
                bus_write(A_EOI_WR, 32'd0);
                chk($sformatf("R9 row %0d level still pending", r), 32'(irq_n), 32'd0);
                src_in = '0;
                tick(4);
                chk($sformatf("R9 row %0d released", r), 32'(irq_n), 32'd1);
            end
            src_in = '0;
            tick(2);
        end

        // ---- nesting, preemption, restore: R5 R6 R7 R8 R10 ----
        do_reset();
        cfg_src(2, 2, 1'b1, 1'b1);
        cfg_src(5, 5, 1'b1, 1'b1);
        cfg_src(6, 3, 1'b1, 1'b1);
        cfg_src(7, 1, 1'b1, 1'b1);
        src_in[2] = 1'b1;
        tick(4);
        chk("R10 edge request", 32'(irq_n), 32'd0);
        bus_read(A_VEC_RD, rd);
        chk("R3 vector src2", rd, vec_of(2));
        chk("R5 drop after ack", 32'(irq_n), 32'd1);
        tick(6);
        chk("R10 held input no re-request", 32'(irq_n), 32'd1);
        pulse(7);
        chk("R6 lower priority waits", 32'(irq_n), 32'd1);
        pulse(5);
        chk("R6 higher priority preempts", 32'(irq_n), 32'd0);
        bus_read(A_VEC_RD, rd);
        chk("R3 vector src5", rd, vec_of(5));
        chk("R5 drop after nested ack", 32'(irq_n), 32'd1);
        pulse(6);
        chk("R6 below current waits", 32'(irq_n), 32'd1);
        bus_write(A_EOI_WR, 32'd0);
        chk("R7 reassert above restored level", 32'(irq_n), 32'd0);
        bus_read(A_VEC_RD, rd);
        chk("R7 vector src6", rd, vec_of(6));
        bus_write(A_EOI_WR, 32'd0);
        chk("R7 no reassert below restored", 32'(irq_n), 32'd1);
        bus_write(A_EOI_WR, 32'd0);
        chk("R7 empty stack reasserts", 32'(irq_n), 32'd0);
        bus_read(A_VEC_RD, rd);
        chk("R7 vector src7", rd, vec_of(7));
        bus_write(A_EOI_WR, 32'd0);
        chk("R10 latch cleared, no request", 32'(irq_n), 32'd1);
        bus_write(A_EOI_WR, 32'd0);
        chk("R8 empty eoi keeps idle", 32'(irq_n), 32'd1);
        pulse(7);
        chk("R8 request after empty eoi", 32'(irq_n), 32'd0);
        bus_read(A_VEC_RD, rd);
        chk("R8 vector after empty eoi", rd, vec_of(7));
        chk("R8 stack sane after empty eoi", 32'(irq_n), 32'd1);
        bus_write(A_EOI_WR, 32'd0);
        src_in = '0;
        tick(4);

        // ---- R2 enable gating ----
        cfg_src(4, 4, 1'b1, 1'b0);
        pulse(4);
        cfg_src(4, 4, 1'b1, 1'b1);
        tick(3);
        chk("R2 edge while disabled ignored", 32'(irq_n), 32'd1);
        cfg_src(9, 6, 1'b0, 1'b0);
        src_in[9] = 1'b1;
        tick(4);
        chk("R2 disabled level source", 32'(irq_n), 32'd1);
        cfg_src(9, 6, 1'b0, 1'b1);
        chk("R2 enabled level source", 32'(irq_n), 32'd0);
        cfg_src(9, 6, 1'b0, 1'b0);
        src_in[9] = 1'b0;
        tick(4);

        // ---- R11 fast path ----
        bus_write(A_FAST_CFG, 32'd3);
        chk("R11 fast idle", 32'(fiq_n), 32'd1);
        fast_in = 1'b1;
        tick(3);
        fast_in = 1'b0;
        tick(3);
        chk("R11 fast edge request", 32'(fiq_n), 32'd0);
        chk("R11 normal line untouched", 32'(irq_n), 32'd1);
        bus_read(A_FVEC_RD, rd);
        chk("R11 fast vector reads zero", rd, 32'd0);
        chk("R11 fast request cancelled", 32'(fiq_n), 32'd1);
        bus_write(A_FAST_CFG, 32'd1);
        fast_in = 1'b1;
        tick(4);
        chk("R11 fast level request", 32'(fiq_n), 32'd0);
        fast_in = 1'b0;
        tick(4);
        chk("R11 fast level released", 32'(fiq_n), 32'd1);

        // ---- R12 eight nested levels ----
        do_reset();
        for (int k = 0; k < 8; k++) cfg_src(k, k, 1'b1, 1'b1);
        cfg_src(8, 7, 1'b1, 1'b1);
        for (int k = 0; k < 8; k++) begin
            pulse(k);
            chk($sformatf("R12 nest level %0d request", k), 32'(irq_n), 32'd0);
            bus_read(A_VEC_RD, rd);
            chk($sformatf("R12 nest level %0d vector", k), rd, vec_of(k));
        end
        pulse(8);
        chk("R12 equal to top waits", 32'(irq_n), 32'd1);
        bus_write(A_EOI_WR, 32'd0);
        chk("R12 R7 pop to level 6 reasserts", 32'(irq_n), 32'd0);
        for (int k = 0; k < 7; k++) bus_write(A_EOI_WR, 32'd0);
        chk("R12 still pending after unwinding", 32'(irq_n), 32'd0);
        bus_read(A_VEC_RD, rd);
        chk("R12 vector src8", rd, vec_of(8));
        bus_write(A_EOI_WR, 32'd0);
        bus_write(A_EOI_WR, 32'd0);
        chk("R12 R8 idle at end", 32'(irq_n), 32'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule